// File: doc/BRIEF.md
# Memory-to-Memory Compare Step Unit

This unit carries out one compare step between two memory operands. The caller supplies two index register values, the current six status flags and the step options. The unit fetches the first operand at the source index and then the second operand at the destination index, through one read port. It subtracts the second operand from the first at the selected width. The difference is thrown away and only the status flags are kept.

After a successful step, both index values move together by the operand size. They move up when the direction flag is clear and down when it is set. The arithmetic stays inside the active address width. The unit rejects illegal requests before any memory traffic: a lock prefix, or a quadword size without 64-bit mode and the width-promotion bit. It reports each step with a single-cycle completion pulse and an error code. The updated index values and flags are valid on that pulse.

Top module: `strcmp_step`

## Requirements
- R1: The flags vector is ordered {OF,SF,ZF,AF,PF,CF}, with CF at bit 0. It is computed from first minus second at the operand width. CF is the borrow out of the top operand bit, ZF is set when the difference is zero, SF is the top bit of the difference, and OF is signed overflow of the subtraction.
- R2: AF is the borrow out of bit 3. PF is set when bits 7..0 of the difference hold an even number of ones.
- R3: op_size encodes 0 byte, 1 word, 2 doubleword and 3 quadword, so both indexes move by 1, 2, 4 or 8. With dir_flag at 0 both indexes increase; with dir_flag at 1 both decrease.
- R4: The address width is 64 in 64-bit mode, or 32 when addr_ovr is set. Outside 64-bit mode it is 32, or 16 when addr_ovr is set. rd_addr is the index value cut to that width. With 16-bit addressing only bits 15..0 of an index change, and they wrap. With 32-bit addressing the new index is the 32-bit wrapped sum with bits 63..32 cleared.
- R5: A quadword request is accepted only when long_mode and wide_pfx are both 1. Any other quadword request completes with err_code 1, issues no read and leaves commit at 0.
- R6: When lock_pfx is set at start, the step completes on the next cycle with err_code 1. No read is issued, commit stays 0, and the index and flag outputs equal their inputs.
- R7: The first read carries segment code seg_ovr_sel when seg_ovr_en is 1, and code 3 otherwise. The second read always carries code 0, whatever the override inputs say. rd_size equals op_size on both reads.
- R8: The first read goes to the source index and the second to the destination index. While rd_valid waits for rd_ready, the request holds its address and segment. A response is taken only on a cycle with rsp_valid high.
- R9: If either read response has rsp_err set, the step completes with err_code 2 and commit 0. src_out, dst_out and flags_out then equal the inputs captured at start.
- R10: done is high for exactly one cycle per accepted start, and commit is 1 with err_code 0 on a successful step. start is taken only while busy is low and is ignored during a step. After reset, busy, done, rd_valid and commit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a step (taken when not busy) |
| op_size | input | 2 | Operand size code |
| dir_flag | input | 1 | 0 step up, 1 step down |
| long_mode | input | 1 | 64-bit mode active |
| wide_pfx | input | 1 | Width-promotion prefix bit |
| addr_ovr | input | 1 | Address-size override |
| lock_pfx | input | 1 | Lock prefix present |
| seg_ovr_en | input | 1 | Replace the first operand's segment |
| seg_ovr_sel | input | 3 | Replacement segment code |
| src_in | input | 64 | Source index value |
| dst_in | input | 64 | Destination index value |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Read address, cut to address width |
| rd_seg | output | 3 | Read segment code |
| rd_size | output | 2 | Read size code |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 64 | Read response data, low bits used |
| rsp_err | input | 1 | Read response fault |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 none, 1 undefined opcode, 2 memory fault |
| commit | output | 1 | Step updated indexes and flags |
| src_out | output | 64 | Resulting source index |
| dst_out | output | 64 | Resulting destination index |
| flags_out | output | 6 | Resulting flags |

## Verification
The assertions check the following on every cycle:
- a completion pulse never lasts two cycles;
- a request waiting on rd_ready keeps its address and segment;
- an erroring completion never commits;
- a lock prefix or an illegal quadword request traps on the next cycle.

The arithmetic can only be shown by the bench's directed scenarios, which compare against independently computed values. That covers the flag values, the size-dependent step and its direction, 16- and 32-bit wrap, segment selection, and the restore of inputs after a memory fault.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;
   typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} opsz_e;
   typedef enum logic [1:0] {AW_16 = 2'd0, AW_32 = 2'd1, AW_64 = 2'd2} aw_e;
   typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_UD = 2'd1, ERR_MEM = 2'd2} err_e;
   typedef enum logic [2:0] {ST_IDLE, ST_RQ1, ST_RS1, ST_RQ2, ST_RS2, ST_FIN} st_e;
   typedef struct packed {
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } flags_t;
endpackage

// File: rtl/strcmp_flags.sv
module strcmp_flags
   import strcmp_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  opsz_e             size,
   output flags_t            f
);
   localparam int NSZ = $clog2(DATA_W / 8) + 1;

   flags_t cand [NSZ];

   // one subtractor slice per operand width, selected by size
   for (genvar k = 0; k < NSZ; k++) begin : g_slice
      localparam int W = 8 << k;
      logic [W:0] d;
      assign d = {1'b0, a[W-1:0]} - {1'b0, b[W-1:0]};
      assign cand[k] = '{of: (a[W-1] ^ b[W-1]) & (d[W-1] ^ a[W-1]),
                         sf: d[W-1],
                         zf: (d[W-1:0] == '0),
                         af: (a[3:0] < b[3:0]),
                         pf: ~^d[7:0],
                         cf: d[W]};
   end

   assign f = cand[size];
endmodule

// File: rtl/strcmp_idx_step.sv
module strcmp_idx_step
   import strcmp_pkg::*;
#(
   parameter int IDX_W = 64
) (
   input  logic [IDX_W-1:0] cur,
   input  opsz_e            size,
   input  logic             dir,
   input  aw_e              aw,
   output logic [IDX_W-1:0] nxt
);
   logic [IDX_W-1:0] step;
   logic [IDX_W-1:0] sum;

   assign step = IDX_W'(1) << size;
   assign sum  = dir ? (cur - step) : (cur + step);

   always_comb begin
      unique case (aw)
         AW_16:   nxt = {cur[IDX_W-1:16], sum[15:0]};
         AW_32:   nxt = {{(IDX_W-32){1'b0}}, sum[31:0]};
         default: nxt = sum;
      endcase
   end
endmodule

// File: rtl/strcmp_ctrl.sv
module strcmp_ctrl
   import strcmp_pkg::*;
#(
   parameter int IDX_W  = 64,
   parameter int DATA_W = 64,
   parameter int SEG_W  = 3,
   parameter int DS_SEG = 3,
   parameter int ES_SEG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_size,
   input  logic              dir_flag,
   input  logic              long_mode,
   input  logic              wide_pfx,
   input  logic              addr_ovr,
   input  logic              lock_pfx,
   input  logic              seg_ovr_en,
   input  logic [SEG_W-1:0]  seg_ovr_sel,
   input  logic [IDX_W-1:0]  src_in,
   input  logic [IDX_W-1:0]  dst_in,
   input  logic [5:0]        flags_in,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [IDX_W-1:0]  rd_addr,
   output logic [SEG_W-1:0]  rd_seg,
   output logic [1:0]        rd_size,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err_code,
   output logic              commit,
   output logic [IDX_W-1:0]  src_out,
   output logic [IDX_W-1:0]  dst_out,
   output logic [5:0]        flags_out,
   output opsz_e             size_q,
   output logic              dir_q,
   output aw_e               aw_q,
   output logic [DATA_W-1:0] op1_q,
   input  logic [IDX_W-1:0]  nxt_src,
   input  logic [IDX_W-1:0]  nxt_dst,
   input  flags_t            new_flags
);
   st_e              state;
   err_e             err_q;
   logic [SEG_W-1:0] seg1_q;
   aw_e              aw_sel;
   logic             illegal;

   assign aw_sel  = long_mode ? (addr_ovr ? AW_32 : AW_64) : (addr_ovr ? AW_16 : AW_32);
   assign illegal = lock_pfx || ((op_size == SZ_Q) && !(long_mode && wide_pfx));

   function automatic logic [IDX_W-1:0] cut(input logic [IDX_W-1:0] v, input aw_e w);
      unique case (w)
         AW_16:   return v & IDX_W'({16{1'b1}});
         AW_32:   return v & IDX_W'({32{1'b1}});
         default: return v;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         err_q     <= ERR_NONE;
         commit    <= 1'b0;
         src_out   <= '0;
         dst_out   <= '0;
         flags_out <= '0;
         size_q    <= SZ_B;
         dir_q     <= 1'b0;
         aw_q      <= AW_32;
         seg1_q    <= SEG_W'(DS_SEG);
         op1_q     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               src_out   <= src_in;
               dst_out   <= dst_in;
               flags_out <= flags_in;
               size_q    <= opsz_e'(op_size);
               dir_q     <= dir_flag;
               aw_q      <= aw_sel;
               seg1_q    <= seg_ovr_en ? seg_ovr_sel : SEG_W'(DS_SEG);
               commit    <= 1'b0;
               err_q     <= illegal ? ERR_UD : ERR_NONE;
               state     <= illegal ? ST_FIN : ST_RQ1;
            end
            ST_RQ1: if (rd_ready) state <= ST_RS1;
            ST_RS1: if (rsp_valid) begin
               if (rsp_err) begin
                  err_q <= ERR_MEM;
                  state <= ST_FIN;
               end else begin
                  op1_q <= rsp_data;
                  state <= ST_RQ2;
               end
            end
            ST_RQ2: if (rd_ready) state <= ST_RS2;
            ST_RS2: if (rsp_valid) begin
               if (rsp_err) begin
                  err_q <= ERR_MEM;
               end else begin
                  flags_out <= new_flags;
                  src_out   <= nxt_src;
                  dst_out   <= nxt_dst;
                  commit    <= 1'b1;
               end
               state <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rd_valid = (state == ST_RQ1) || (state == ST_RQ2);
   assign rd_addr  = cut((state == ST_RQ2) ? dst_out : src_out, aw_q);
   assign rd_seg   = (state == ST_RQ2) ? SEG_W'(ES_SEG) : seg1_q;
   assign rd_size  = size_q;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FIN);
   assign err_code = err_q;
endmodule

// File: rtl/strcmp_step.sv
module strcmp_step
   import strcmp_pkg::*;
#(
   parameter int IDX_W  = 64,
   parameter int DATA_W = 64,
   parameter int SEG_W  = 3,
   parameter int DS_SEG = 3,
   parameter int ES_SEG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_size,
   input  logic              dir_flag,
   input  logic              long_mode,
   input  logic              wide_pfx,
   input  logic              addr_ovr,
   input  logic              lock_pfx,
   input  logic              seg_ovr_en,
   input  logic [SEG_W-1:0]  seg_ovr_sel,
   input  logic [IDX_W-1:0]  src_in,
   input  logic [IDX_W-1:0]  dst_in,
   input  logic [5:0]        flags_in,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [IDX_W-1:0]  rd_addr,
   output logic [SEG_W-1:0]  rd_seg,
   output logic [1:0]        rd_size,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err_code,
   output logic              commit,
   output logic [IDX_W-1:0]  src_out,
   output logic [IDX_W-1:0]  dst_out,
   output logic [5:0]        flags_out
);
   localparam int NPTR = 2;

   if (IDX_W != 64) begin : g_bad_idx
      $error("strcmp_step: IDX_W must be 64");
   end
   if (DATA_W != 64) begin : g_bad_data
      $error("strcmp_step: DATA_W must be 64");
   end
   if ((DS_SEG == ES_SEG) || (DS_SEG >= (1 << SEG_W)) || (ES_SEG >= (1 << SEG_W))) begin : g_bad_seg
      $error("strcmp_step: segment codes must be distinct and fit SEG_W");
   end

   opsz_e             size_q;
   logic              dir_q;
   aw_e               aw_q;
   logic [DATA_W-1:0] op1_q;
   flags_t            new_flags;
   logic [IDX_W-1:0]  ptr_cur [NPTR];
   logic [IDX_W-1:0]  ptr_nxt [NPTR];

   assign ptr_cur[0] = src_out;
   assign ptr_cur[1] = dst_out;

   strcmp_ctrl #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .DS_SEG(DS_SEG), .ES_SEG(ES_SEG)
   ) u_ctrl (
      .clk, .rst_n, .start, .op_size, .dir_flag, .long_mode, .wide_pfx, .addr_ovr,
      .lock_pfx, .seg_ovr_en, .seg_ovr_sel, .src_in, .dst_in, .flags_in,
      .rd_valid, .rd_ready, .rd_addr, .rd_seg, .rd_size,
      .rsp_valid, .rsp_data, .rsp_err,
      .busy, .done, .err_code, .commit, .src_out, .dst_out, .flags_out,
      .size_q, .dir_q, .aw_q, .op1_q,
      .nxt_src(ptr_nxt[0]), .nxt_dst(ptr_nxt[1]), .new_flags
   );

   strcmp_flags #(.DATA_W(DATA_W)) u_flags (
      .a(op1_q), .b(rsp_data), .size(size_q), .f(new_flags)
   );

   for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      strcmp_idx_step #(.IDX_W(IDX_W)) u_step (
         .cur(ptr_cur[p]), .size(size_q), .dir(dir_q), .aw(aw_q), .nxt(ptr_nxt[p])
      );
   end
endmodule

// File: rtl/strcmp_step_chk.sv
module strcmp_step_chk #(
   parameter int IDX_W = 64,
   parameter int SEG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [1:0]       op_size,
   input logic             long_mode,
   input logic             wide_pfx,
   input logic             lock_pfx,
   input logic             rd_valid,
   input logic             rd_ready,
   input logic [IDX_W-1:0] rd_addr,
   input logic [SEG_W-1:0] rd_seg,
   input logic             busy,
   input logic             done,
   input logic [1:0]       err_code,
   input logic             commit
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R10
   AST_LOCK_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && lock_pfx) |=> (done && err_code == 2'd1 && !commit && !rd_valid)); // R6
   AST_QWORD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_size == 2'd3 && !(long_mode && wide_pfx))
      |=> (done && err_code == 2'd1 && !rd_valid)); // R5
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_seg))); // R8
   AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code != 2'd0) |-> !commit); // R9
endmodule

bind strcmp_step strcmp_step_chk #(.IDX_W(IDX_W), .SEG_W(SEG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size), .long_mode(long_mode),
   .wide_pfx(wide_pfx), .lock_pfx(lock_pfx), .rd_valid(rd_valid), .rd_ready(rd_ready),
   .rd_addr(rd_addr), .rd_seg(rd_seg), .busy(busy), .done(done), .err_code(err_code),
   .commit(commit)
);

// File: tb/strcmp_step_test.sv
module strcmp_step_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_size = '0;
   logic        dir_flag = 1'b0, long_mode = 1'b0, wide_pfx = 1'b0, addr_ovr = 1'b0;
   logic        lock_pfx = 1'b0, seg_ovr_en = 1'b0;
   logic [2:0]  seg_ovr_sel = '0;
   logic [63:0] src_in = '0, dst_in = '0;
   logic [5:0]  flags_in = '0;
   logic        rd_valid, rd_ready = 1'b0;
   logic [63:0] rd_addr;
   logic [2:0]  rd_seg;
   logic [1:0]  rd_size;
   logic        rsp_valid = 1'b0, rsp_err = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        busy, done, commit;
   logic [1:0]  err_code;
   logic [63:0] src_out, dst_out;
   logic [5:0]  flags_out;

   int checks = 0;
   int errors = 0;

   strcmp_step uut (.*);

   always #4 clk = ~clk;

   // scenario settings
   int          s_size, s_fault, s_stall, s_lat;
   logic        s_dir, s_lm, s_wide, s_aovr, s_lock, s_sen, s_hold;
   logic [2:0]  s_ssel;
   logic [63:0] s_src, s_dst, s_d1, s_d2;
   logic [5:0]  s_fin;
   // results
   logic        r_done, r_commit, r_stable;
   logic [1:0]  r_err;
   logic [63:0] r_src, r_dst;
   logic [5:0]  r_flags;
   int          r_nreads;
   logic [63:0] r_addr [2];
   logic [2:0]  r_seg [2];
   logic [1:0]  r_size [2];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int exp_aw(input logic lm, input logic ao);
      if (lm) return ao ? 32 : 64;
      return ao ? 16 : 32;
   endfunction

   function automatic logic [63:0] exp_cut(input logic [63:0] v, input int aw);
      if (aw == 16) return v & 64'hFFFF;
      if (aw == 32) return v & 64'hFFFF_FFFF;
      return v;
   endfunction

   function automatic logic [63:0] exp_next(input logic [63:0] v, input int sz, input logic dir, input int aw);
      logic [63:0] st, n;
      st = 64'd1 << sz;
      n  = dir ? v - st : v + st;
      if (aw == 16) return {v[63:16], n[15:0]};
      if (aw == 32) return {32'd0, n[31:0]};
      return n;
   endfunction

   function automatic logic [5:0] exp_flags(input int sz, input logic [63:0] a, input logic [63:0] b);
      int w;
      logic [63:0] m, ua, ub, d;
      logic signed [67:0] sa, sb, sr, lim;
      logic of;
      w  = 8 << sz;
      m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      ua = a & m;
      ub = b & m;
      d  = (ua - ub) & m;
      sa = $signed({4'd0, ua});
      sb = $signed({4'd0, ub});
      if (ua[w-1]) sa = sa - (68'sd1 <<< w);
      if (ub[w-1]) sb = sb - (68'sd1 <<< w);
      sr  = sa - sb;
      lim = 68'sd1 <<< (w - 1);
      of  = (sr > lim - 68'sd1) || (sr < -lim);
      return {of, d[w-1], (d == 64'd0), (a[3:0] < b[3:0]), ~^d[7:0], (ua < ub)};
   endfunction

   task automatic set_defaults();
      s_size = 0; s_fault = 0; s_stall = 0; s_lat = 1;
      s_dir = 0; s_lm = 0; s_wide = 0; s_aovr = 0; s_lock = 0; s_sen = 0; s_hold = 0;
      s_ssel = 3'd5; s_src = 64'h1000; s_dst = 64'h2000; s_d1 = 0; s_d2 = 0; s_fin = 6'b0;
   endtask

   task automatic run_step();
      int rsp_wait = -1;
      int stall_left = 0;
      logic waiting = 1'b0;
      r_done = 0; r_nreads = 0; r_stable = 1;
      @(negedge clk);
      op_size = 2'(s_size); dir_flag = s_dir; long_mode = s_lm; wide_pfx = s_wide;
      addr_ovr = s_aovr; lock_pfx = s_lock; seg_ovr_en = s_sen; seg_ovr_sel = s_ssel;
      src_in = s_src; dst_in = s_dst; flags_in = s_fin;
      start = 1'b1;
      @(negedge clk);
      if (!s_hold) start = 1'b0;
      for (int cyc = 0; cyc < 200; cyc++) begin
         rd_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
         if (done) begin
            start = 1'b0;
            r_done = 1; r_err = err_code; r_commit = commit;
            r_src = src_out; r_dst = dst_out; r_flags = flags_out;
            break;
         end
         if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
               rsp_valid = 1'b1;
               rsp_data  = (r_nreads == 1) ? s_d1 : s_d2;
               rsp_err   = (s_fault == r_nreads);
               rsp_wait  = -1;
            end
         end else if (rd_valid && r_nreads < 2) begin
            if (!waiting) begin
               r_addr[r_nreads] = rd_addr; r_seg[r_nreads] = rd_seg; r_size[r_nreads] = rd_size;
               waiting = 1'b1; stall_left = s_stall;
            end else if (rd_addr !== r_addr[r_nreads] || rd_seg !== r_seg[r_nreads]) begin
               r_stable = 0;
            end
            if (stall_left > 0) stall_left--;
            else begin
               rd_ready = 1'b1; waiting = 1'b0; r_nreads++; rsp_wait = s_lat;
            end
         end
         @(negedge clk);
      end
   endtask

   task automatic check_ok(input string tag);
      int aw;
      aw = exp_aw(s_lm, s_aovr);
      chk({tag, " R10 done"}, 64'(r_done), 64'd1);
      chk({tag, " R10 err"}, 64'(r_err), 64'd0);
      chk({tag, " R10 commit"}, 64'(r_commit), 64'd1);
      chk({tag, " R1 R2 flags"}, 64'(r_flags), 64'(exp_flags(s_size, s_d1, s_d2)));
      chk({tag, " R3 R4 src"}, r_src, exp_next(s_src, s_size, s_dir, aw));
      chk({tag, " R3 R4 dst"}, r_dst, exp_next(s_dst, s_size, s_dir, aw));
      chk({tag, " R8 reads"}, 64'(r_nreads), 64'd2);
      chk({tag, " R4 R8 addr1"}, r_addr[0], exp_cut(s_src, aw));
      chk({tag, " R4 R8 addr2"}, r_addr[1], exp_cut(s_dst, aw));
      chk({tag, " R7 seg1"}, 64'(r_seg[0]), s_sen ? 64'(s_ssel) : 64'd3);
      chk({tag, " R7 seg2"}, 64'(r_seg[1]), 64'd0);
      chk({tag, " R7 size"}, 64'(r_size[1]), 64'(s_size));
   endtask

   task automatic check_trap(input string tag, input logic [1:0] code, input int reads);
      chk({tag, " done"}, 64'(r_done), 64'd1);
      chk({tag, " err"}, 64'(r_err), 64'(code));
      chk({tag, " commit"}, 64'(r_commit), 64'd0);
      chk({tag, " reads"}, 64'(r_nreads), 64'(reads));
      chk({tag, " src kept"}, r_src, s_src);
      chk({tag, " dst kept"}, r_dst, s_dst);
      chk({tag, " flags kept"}, 64'(r_flags), 64'(s_fin));
   endtask

   task automatic t_reset();
      chk("R10 reset busy", 64'(busy), 64'd0);
      chk("R10 reset done", 64'(done), 64'd0);
      chk("R10 reset rd_valid", 64'(rd_valid), 64'd0);
      chk("R10 reset commit", 64'(commit), 64'd0);
   endtask

   task automatic t_byte_equal();
      set_defaults(); s_d1 = 64'h5A; s_d2 = 64'h5A; s_fin = 6'b111111;
      run_step(); check_ok("byte equal");
      chk("R1 byte equal ZF", 64'(r_flags[3]), 64'd1);
   endtask

   task automatic t_word_borrow_down();
      set_defaults(); s_size = 1; s_dir = 1; s_d1 = 64'h0001; s_d2 = 64'h0002;
      run_step(); check_ok("word borrow");
      chk("R1 R2 word borrow CF/SF/AF", 64'(r_flags), 64'b010111);
   endtask

   task automatic t_dword_overflow_seg();
      set_defaults(); s_size = 2; s_sen = 1; s_ssel = 3'd4;
      s_d1 = 64'hFFFF_FFFF_8000_0000; s_d2 = 64'h1;
      run_step(); check_ok("dword overflow");
      chk("R1 dword OF", 64'(r_flags[5]), 64'd1);
   endtask

   task automatic t_qword_long();
      set_defaults(); s_size = 3; s_lm = 1; s_wide = 1; s_dir = 1;
      s_src = 64'hABCD_0000_0000_0004; s_dst = 64'h0000_0001_0000_0000;
      s_d1 = 64'h8000_0000_0000_0000; s_d2 = 64'h7FFF_FFFF_FFFF_FFFF;
      run_step(); check_ok("R5 qword long");
   endtask

   task automatic t_qword_illegal();
      set_defaults(); s_size = 3; s_wide = 1; s_fin = 6'b101010;
      run_step(); check_trap("R5 qword legacy", 2'd1, 0);
      set_defaults(); s_size = 3; s_lm = 1; s_wide = 0;
      run_step(); check_trap("R5 qword no prefix", 2'd1, 0);
   endtask

   task automatic t_lock();
      set_defaults(); s_lock = 1; s_fin = 6'b010101;
      run_step(); check_trap("R6 lock", 2'd1, 0);
   endtask

   task automatic t_addr16_wrap();
      set_defaults(); s_aovr = 1; s_size = 1;
      s_src = 64'h1234_5678_9ABC_FFFF; s_dst = 64'h0000_0000_0001_0003;
      s_d1 = 64'h7; s_d2 = 64'h7;
      run_step(); check_ok("R4 addr16 wrap");
      chk("R4 addr16 src", r_src, 64'h1234_5678_9ABC_0001);
   endtask

   task automatic t_addr32_long();
      set_defaults(); s_lm = 1; s_aovr = 1; s_dir = 1; s_size = 2;
      s_src = 64'hDEAD_BEEF_0000_0002; s_dst = 64'h1111_2222_3333_4444;
      s_d1 = 64'h10; s_d2 = 64'h20;
      run_step(); check_ok("R4 addr32 long");
      chk("R4 addr32 src", r_src, 64'h0000_0000_FFFF_FFFE);
   endtask

   task automatic t_faults();
      set_defaults(); s_fault = 1; s_fin = 6'b110011; s_d1 = 1; s_d2 = 2;
      run_step(); check_trap("R9 fault first", 2'd2, 1);
      set_defaults(); s_fault = 2; s_fin = 6'b001100; s_d1 = 1; s_d2 = 2;
      run_step(); check_trap("R9 fault second", 2'd2, 2);
   endtask

   task automatic t_stall();
      set_defaults(); s_stall = 3; s_lat = 4; s_size = 1; s_d1 = 64'h8000; s_d2 = 64'h0001;
      run_step(); check_ok("R8 stall");
      chk("R8 request held", 64'(r_stable), 64'd1);
   endtask

   task automatic t_busy_ignore();
      set_defaults(); s_hold = 1; s_lat = 2; s_d1 = 64'h30; s_d2 = 64'h31;
      run_step(); check_ok("R10 start held");
      @(negedge clk);
      chk("R10 idle after step", 64'(busy), 64'd0);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_equal();
      t_word_borrow_down();
      t_dword_overflow_seg();
      t_qword_long();
      t_qword_illegal();
      t_lock();
      t_addr16_wrap();
      t_addr32_long();
      t_faults();
      t_stall();
      t_busy_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule